// File: doc/BRIEF.md
# CPU Reset and Halt Sequencer

This block is the reset and halt/hold front end of a small 8-bit processor's timing unit. It brings an asynchronous active-low reset pin and a supply-good level into the clock domain, holds the machine in a reset T-state for as long as either one demands it, and then starts execution at the first T-state of an opcode fetch. The sequence of T-states is published as a one-hot vector. A bus output enable is derived from it so that the bus floats while the machine is idle.

While the machine sits in the reset T-state, the block drives level strobes that clear the interrupt and control flip-flops kept elsewhere and set the three interrupt mask bits. Outside reset it walks machine cycles, parks in a halt state on request, and grants hold at the end of a machine cycle or from halt. It also handles the case where an interrupt is accepted while a halted machine is held off the bus. Interrupt sampling is then inhibited until the hold is released, and execution resumes at once instead of returning to halt.

Top module: `cpu_reset_seq`

## Requirements
- R1: A low level on `reset_in_ni` passes through a two-flop synchronizer and one further latch stage. When the pin is driven low before a rising edge, `reset_o` is high and the reset T-state is entered after the fourth rising edge. A pulse held low across three rising edges is always recognized.
- R2: After `rst_ni` is released with `pwr_good_i` high and `reset_in_ni` high, the machine stays in the reset T-state and leaves it on rising edge POR_CYCLES+4.
- R3: When `reset_in_ni` returns high, the machine is still in reset after three rising edges and is in T1 after the fourth edge. The state following reset is always T1.
- R4: `tstate_o` is always one-hot, with bit 0 = T1, 1 = T2, 2 = T3, 3 = T4, 4 = T5, 5 = reset, 6 = halt and 7 = hold.
- R5: Outside reset, halt and hold, the states run T1, T2, T3, T4, then T1 again. If `six_state_i` is high in T4, the next state is T5, and T5 is followed by T1.
- R6: `bus_en_o` is low in the reset, halt and hold states and high in T1 to T5.
- R7: In the reset state, `clr_o` is all ones and `mask_set_o` is 3'b111. In every other state both are zero. The `clr_o` bit order is 0 program counter, 1 instruction register, 2 interrupt enable, 3 edge-triggered interrupt latch, 4 trap latch, 5 serial output flop, 6 machine-state flops, 7 machine-cycle flops, 8 hold latch, 9 interrupt-request latch, 10 ready latch. `mask_set_o` bits 0 to 2 set the masks of the three maskable lines in rising priority.
- R8: Reset overrides hold and halt. In the reset state `hlda_o` and `sample_inh_o` are low, and a `hold_i` that stays high through reset does not stop the move to T1.
- R9: If `halt_req_i` is high at the end of a machine cycle (T4 with `six_state_i` low, or T5) and no hold is latched, the next state is halt. In halt, a high `intr_acc_i` moves the machine to T1 on the next edge.
- R10: `hold_i` is registered once. A latched hold moves the machine to the hold state on the next edge if the machine is at the end of a machine cycle or in halt, and hold wins over a halt request. `hlda_o` is high exactly in the hold state. The hold state is left on the second edge after `hold_i` falls, to T1, or back to halt if the hold was entered from halt and no interrupt was accepted.
- R11: When the hold was entered from halt, an `intr_acc_i` pulse during that hold, or on the edge that takes halt into hold, raises `sample_inh_o`. The signal stays high until the hold ends, and the machine then goes to T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's flops |
| pwr_good_i | input | 1 | Supply-good level that starts the power-on count |
| reset_in_ni | input | 1 | Asynchronous active-low processor reset pin |
| hold_i | input | 1 | Bus hold request |
| halt_req_i | input | 1 | Halt request, sampled at the end of a machine cycle |
| six_state_i | input | 1 | Extend the current machine cycle to T5 |
| intr_acc_i | input | 1 | Interrupt accepted |
| tstate_o | output | 8 | One-hot T-state |
| reset_o | output | 1 | Reset output, high in the reset state |
| bus_en_o | output | 1 | Bus and control output enable |
| hlda_o | output | 1 | Hold acknowledge |
| sample_inh_o | output | 1 | Interrupt sampling inhibit |
| clr_o | output | 11 | Clear strobes for control flip-flops |
| mask_set_o | output | 3 | Set strobes for interrupt masks |

## Verification
Two functions can land on the same edge in halt: a latched hold request and an accepted interrupt. The bench raises `hold_i`, waits until it has been latched, and raises `intr_acc_i` in the same cycle in which the halt-to-hold transition happens. It expects the hold state with `sample_inh_o` already high, and T1 rather than halt once the hold drops. A second collision is a reset arriving while hold is granted and the hold request stays high through reset. Here the bench expects the reset state with `hlda_o` and `sample_inh_o` low, and a clean T1 afterwards.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  localparam int NUM_TS  = 8;
  localparam int TS_T1   = 0;
  localparam int TS_T2   = 1;
  localparam int TS_T3   = 2;
  localparam int TS_T4   = 3;
  localparam int TS_T5   = 4;
  localparam int TS_RST  = 5;
  localparam int TS_HALT = 6;
  localparam int TS_HOLD = 7;
  localparam int CLR_W   = 11;
  localparam int MASK_W  = 3;

  typedef logic [NUM_TS-1:0] tstate_t;

  function automatic tstate_t ts_hot(input int idx);
    return tstate_t'(1) << idx;
  endfunction
endpackage

// File: rtl/cpu_rst_sync.sv
module cpu_rst_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_in_ni,
  input  logic pwr_good_i,
  output logic run_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] rsync_q, psync_q;
  logic         por_done;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsync_q <= '0;
      psync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[MSB-1:0], reset_in_ni};
      psync_q <= {psync_q[MSB-1:0], pwr_good_i};
    end
  end

  generate
    if (POR_CYCLES == 0) begin : g_no_por
      assign por_done = psync_q[MSB];
    end else begin : g_por
      localparam int CW = $clog2(POR_CYCLES + 1);
      localparam logic [CW-1:0] CMAX = CW'(POR_CYCLES);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (!psync_q[MSB])  cnt_q <= '0;
        else if (cnt_q != CMAX)  cnt_q <= cnt_q + 1'b1;
      end
      assign por_done = (cnt_q == CMAX);
    end
  endgenerate

  // high-phase latch stage: acted on one T-state later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= rsync_q[MSB] & por_done;
  end

  assign run_o = run_q;
endmodule

// File: rtl/cpu_tstate_fsm.sv
module cpu_tstate_fsm
  import cpu_rst_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    hold_i,
  input  logic    halt_req_i,
  input  logic    six_state_i,
  input  logic    intr_acc_i,
  output tstate_t tstate_o,
  output logic    sample_inh_o
);
  tstate_t ts_q, ts_d;
  logic    hold_q;
  logic    from_halt_q, from_halt_d;
  logic    pend_q, pend_d;
  tstate_t cyc_end;

  always_comb begin
    if (hold_q)          cyc_end = ts_hot(TS_HOLD);
    else if (halt_req_i) cyc_end = ts_hot(TS_HALT);
    else                 cyc_end = ts_hot(TS_T1);
  end

  always_comb begin
    ts_d        = ts_q;
    from_halt_d = from_halt_q;
    pend_d      = pend_q;
    if (!run_i) begin
      ts_d        = ts_hot(TS_RST);
      from_halt_d = 1'b0;
      pend_d      = 1'b0;
    end else begin
      case (1'b1)
        ts_q[TS_T1]: ts_d = ts_hot(TS_T2);
        ts_q[TS_T2]: ts_d = ts_hot(TS_T3);
        ts_q[TS_T3]: ts_d = ts_hot(TS_T4);
        ts_q[TS_T4]: ts_d = six_state_i ? ts_hot(TS_T5) : cyc_end;
        ts_q[TS_T5]: ts_d = cyc_end;
        ts_q[TS_RST]: ts_d = ts_hot(TS_T1);
        ts_q[TS_HALT]: begin
          if (hold_q) begin
            ts_d        = ts_hot(TS_HOLD);
            from_halt_d = 1'b1;
            pend_d      = intr_acc_i;
          end else if (intr_acc_i) begin
            ts_d = ts_hot(TS_T1);
          end
        end
        ts_q[TS_HOLD]: begin
          if (from_halt_q && intr_acc_i) pend_d = 1'b1;
          if (!hold_q) begin
            ts_d = (from_halt_q && !(pend_q || intr_acc_i)) ?
                   ts_hot(TS_HALT) : ts_hot(TS_T1);
            from_halt_d = 1'b0;
            pend_d      = 1'b0;
          end
        end
        default: ts_d = ts_hot(TS_RST);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q        <= ts_hot(TS_RST);
      hold_q      <= 1'b0;
      from_halt_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      ts_q        <= ts_d;
      hold_q      <= run_i & hold_i;
      from_halt_q <= from_halt_d;
      pend_q      <= pend_d;
    end
  end

  assign tstate_o     = ts_q;
  assign sample_inh_o = pend_q;
endmodule

// File: rtl/cpu_rst_strobes.sv
module cpu_rst_strobes
  import cpu_rst_pkg::*;
(
  input  logic              in_rst_i,
  input  logic              in_halt_i,
  input  logic              in_hold_i,
  output logic              reset_o,
  output logic              bus_en_o,
  output logic              hlda_o,
  output logic [CLR_W-1:0]  clr_o,
  output logic [MASK_W-1:0] mask_set_o
);
  genvar gi;
  generate
    for (gi = 0; gi < CLR_W; gi++) begin : g_clr
      assign clr_o[gi] = in_rst_i;
    end
    for (gi = 0; gi < MASK_W; gi++) begin : g_mask
      assign mask_set_o[gi] = in_rst_i;
    end
  endgenerate

  assign reset_o  = in_rst_i;
  assign hlda_o   = in_hold_i;
  assign bus_en_o = ~(in_rst_i | in_halt_i | in_hold_i);
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import cpu_rst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              reset_in_ni,
  input  logic              hold_i,
  input  logic              halt_req_i,
  input  logic              six_state_i,
  input  logic              intr_acc_i,
  output logic [NUM_TS-1:0] tstate_o,
  output logic              reset_o,
  output logic              bus_en_o,
  output logic              hlda_o,
  output logic              sample_inh_o,
  output logic [CLR_W-1:0]  clr_o,
  output logic [MASK_W-1:0] mask_set_o
);
  logic    run;
  tstate_t ts;

  cpu_rst_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .POR_CYCLES (POR_CYCLES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reset_in_ni(reset_in_ni),
    .pwr_good_i (pwr_good_i),
    .run_o      (run)
  );

  cpu_tstate_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .hold_i      (hold_i),
    .halt_req_i  (halt_req_i),
    .six_state_i (six_state_i),
    .intr_acc_i  (intr_acc_i),
    .tstate_o    (ts),
    .sample_inh_o(sample_inh_o)
  );

  cpu_rst_strobes u_strb (
    .in_rst_i  (ts[TS_RST]),
    .in_halt_i (ts[TS_HALT]),
    .in_hold_i (ts[TS_HOLD]),
    .reset_o   (reset_o),
    .bus_en_o  (bus_en_o),
    .hlda_o    (hlda_o),
    .clr_o     (clr_o),
    .mask_set_o(mask_set_o)
  );

  assign tstate_o = ts;
endmodule

// File: rtl/cpu_reset_seq_chk.sv
module cpu_reset_seq_chk
  import cpu_rst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_TS-1:0] tstate_o,
  input logic              reset_o,
  input logic              bus_en_o,
  input logic              hlda_o,
  input logic              sample_inh_o,
  input logic [CLR_W-1:0]  clr_o,
  input logic [MASK_W-1:0] mask_set_o
);
  assert_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tstate_o) == 1);

  assert_resume_t1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_o) |-> tstate_o[TS_T1]);

  assert_fetch_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tstate_o[TS_T1] |=> (tstate_o[TS_T2] || reset_o));

  assert_t5_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tstate_o[TS_T5] |=> !(tstate_o[TS_T2] || tstate_o[TS_T3] ||
                          tstate_o[TS_T4] || tstate_o[TS_T5]));

  assert_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_o || hlda_o || tstate_o[TS_HALT]) |-> !bus_en_o);

  assert_strobes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> ((&clr_o) && (&mask_set_o)));

  assert_no_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_o |-> (clr_o == '0 && mask_set_o == '0));

  assert_reset_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> (!hlda_o && !sample_inh_o));

  assert_hold_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hlda_o) && !reset_o) |-> (tstate_o[TS_T1] || tstate_o[TS_HALT]));

  assert_inhibit_in_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_inh_o |-> hlda_o);

  assert_inhibit_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_inh_o && !hlda_o) |=> 1'b0 || !sample_inh_o);
endmodule

bind cpu_reset_seq cpu_reset_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tstate_o    (tstate_o),
  .reset_o     (reset_o),
  .bus_en_o    (bus_en_o),
  .hlda_o      (hlda_o),
  .sample_inh_o(sample_inh_o),
  .clr_o       (clr_o),
  .mask_set_o  (mask_set_o)
);

// File: tb/cpu_reset_seq_test.sv
`timescale 1ns/1ps
module cpu_reset_seq_test;
  localparam int P = 5;
  localparam logic [7:0] S_T1 = 8'h01, S_T2 = 8'h02, S_T3 = 8'h04, S_T4 = 8'h08,
                         S_T5 = 8'h10, S_RS = 8'h20, S_HL = 8'h40, S_HD = 8'h80;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b1, reset_in_ni = 1'b1, hold_i = 1'b0;
  logic halt_req_i = 1'b0, six_state_i = 1'b0, intr_acc_i = 1'b0;
  logic [7:0]  tstate_o;
  logic        reset_o, bus_en_o, hlda_o, sample_inh_o;
  logic [10:0] clr_o;
  logic [2:0]  mask_set_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cpu_reset_seq #(.SYNC_STAGES(2), .POR_CYCLES(P)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .reset_in_ni(reset_in_ni), .hold_i(hold_i), .halt_req_i(halt_req_i),
    .six_state_i(six_state_i), .intr_acc_i(intr_acc_i),
    .tstate_o(tstate_o), .reset_o(reset_o), .bus_en_o(bus_en_o),
    .hlda_o(hlda_o), .sample_inh_o(sample_inh_o), .clr_o(clr_o),
    .mask_set_o(mask_set_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // state plus derived outputs (R4, R6, R7, R10)
  task automatic chk_ts(input string req, input logic [7:0] exp);
    logic idle;
    idle = (exp == S_RS) || (exp == S_HL) || (exp == S_HD);
    chk(req, tstate_o, exp);
    chk({req, " R6 bus_en"}, bus_en_o, !idle);
    chk({req, " R10 hlda"}, hlda_o, exp == S_HD);
    chk({req, " R7 clr"}, clr_o, (exp == S_RS) ? 11'h7FF : 11'h0);
    chk({req, " R7 mask"}, mask_set_o, (exp == S_RS) ? 3'b111 : 3'b000);
  endtask

  task automatic to_halt();
    while (tstate_o != S_T4) step();
    halt_req_i = 1'b1;
    step();
    halt_req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    chk_ts("R7 reset state", S_RS);
    chk("R8 reset inh", sample_inh_o, 1'b0);
    step(2);
    rst_ni = 1'b1;
    // R2 power-on count
    n = 0;
    while (reset_o && n < 100) begin
      step();
      n++;
    end
    chk("R2 por release edge", n, P + 4);
    chk_ts("R3 first state T1", S_T1);

    // R5 fetch order
    step(); chk_ts("R5 T2", S_T2);
    step(); chk_ts("R5 T3", S_T3);
    step(); chk_ts("R5 T4", S_T4);
    six_state_i = 1'b1;
    step(); chk_ts("R5 T5", S_T5);
    six_state_i = 1'b0;
    step(); chk_ts("R5 T5 to T1", S_T1);
    step(3); chk_ts("R5 T4 again", S_T4);
    step(); chk_ts("R5 T4 to T1", S_T1);

    // R9 halt entry and exit
    to_halt();
    chk_ts("R9 halt entered", S_HL);
    step(3);
    chk_ts("R9 halt stays", S_HL);
    intr_acc_i = 1'b1;
    step();
    intr_acc_i = 1'b0;
    chk_ts("R9 halt exit to T1", S_T1);

    // R10 hold from running
    hold_i = 1'b1;
    step(3); chk_ts("R10 T4 before hold", S_T4);
    step(); chk_ts("R10 hold entered", S_HD);
    step(2); chk_ts("R10 hold stays", S_HD);
    hold_i = 1'b0;
    step(); chk_ts("R10 hold one edge after drop", S_HD);
    step(); chk_ts("R10 hold exit to T1", S_T1);

    // R10 hold wins over halt request
    hold_i = 1'b1;
    step(3);
    halt_req_i = 1'b1;
    step();
    halt_req_i = 1'b0;
    chk_ts("R10 hold beats halt", S_HD);
    hold_i = 1'b0;
    step(2); chk_ts("R10 exit after priority", S_T1);

    // R10 hold from halt, no interrupt: back to halt
    to_halt();
    hold_i = 1'b1;
    step(); chk_ts("R10 latch delay in halt", S_HL);
    step(); chk_ts("R10 halt to hold", S_HD);
    chk("R11 no inhibit", sample_inh_o, 1'b0);
    hold_i = 1'b0;
    step(2); chk_ts("R10 back to halt", S_HL);
    intr_acc_i = 1'b1;
    step();
    intr_acc_i = 1'b0;
    chk_ts("R9 exit after hold", S_T1);

    // R11 interrupt during halt-hold
    to_halt();
    hold_i = 1'b1;
    step(2); chk_ts("R11 hold from halt", S_HD);
    intr_acc_i = 1'b1;
    step();
    intr_acc_i = 1'b0;
    chk("R11 inhibit raised", sample_inh_o, 1'b1);
    step();
    chk("R11 inhibit held", sample_inh_o, 1'b1);
    hold_i = 1'b0;
    step(); chk("R11 inhibit until exit", sample_inh_o, 1'b1);
    step(); chk_ts("R11 resume T1", S_T1);
    chk("R11 inhibit cleared", sample_inh_o, 1'b0);

    // R11 same-edge: hold latched and interrupt accepted in halt
    to_halt();
    hold_i = 1'b1;
    step();
    intr_acc_i = 1'b1;
    step();
    intr_acc_i = 1'b0;
    chk_ts("R11 same edge hold", S_HD);
    chk("R11 same edge inhibit", sample_inh_o, 1'b1);
    hold_i = 1'b0;
    step(2); chk_ts("R11 same edge resume", S_T1);

    // R1 / R8 reset during hold, hold kept high
    hold_i = 1'b1;
    step(4); chk_ts("R8 hold before reset", S_HD);
    reset_in_ni = 1'b0;
    step(3); chk_ts("R1 not yet reset", S_HD);
    step(); chk_ts("R1 reset after four edges", S_RS);
    chk("R8 inhibit low in reset", sample_inh_o, 1'b0);
    step(2);
    reset_in_ni = 1'b1;
    step(3); chk_ts("R3 still reset", S_RS);
    step(); chk_ts("R8 T1 despite hold", S_T1);
    hold_i = 1'b0;
    step(8);

    // R1 three-cycle pulse from T-states
    while (tstate_o != S_T2) step();
    reset_in_ni = 1'b0;
    step(3);
    reset_in_ni = 1'b1;
    step(); chk_ts("R1 short pulse recognized", S_RS);
    step(2); chk_ts("R3 pulse still reset", S_RS);
    step(); chk_ts("R3 pulse resume T1", S_T1);
    step(); chk_ts("R5 after pulse T2", S_T2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule